// File: doc/BRIEF.md
# Nonvolatile Memory Access Controller

This block sits on the register bus of a small 8-bit processor core. Through it the core reads and writes two on-chip nonvolatile arrays: a 64-byte data store and a 2048-word, 14-bit program store. Software selects the target array and sets an address, and for a write it also loads the data. It then sets a read or write strobe in a control register. The block drives the array ports, loads read results into its data registers and times each erase-and-program cycle with its own countdown.

A write only starts after a guard sequence. Two key bytes must arrive at a storage-less unlock port, and a write-enable bit must be set. A data-store write runs in the background. A program-store write stalls the core until it finishes. Interrupt requests that arrive during that stall are held and passed on after the write completes.

Register offsets are 0 control, 1 unlock, 2 address low, 3 address high (5 bits), 4 data low, 5 data high (6 bits). Control bits are bit 0 read strobe, bit 1 write strobe, bit 2 write enable, bit 3 error, and bit 7 space select (0 selects the data store, 1 the program store).

Top module: `nvmAccessCtrl`

## Requirements
- R1: After reset every register reads 0x00, and coreStall, doneP and irqOut are low.
- R2: With space select 0, a read uses address-low bits 5:0, so 0x40 reaches location 0x00. The read strobe reads 1 in the cycle after the control write. The byte appears in data low in the following cycle, and the strobe reads 0 in that cycle.
- R3: With space select 1, a read uses the low 11 bits of {address high, address low}, so 0x0800 reaches 0x0000. The read strobe reads 1 for two cycles. After that, data high bits 5:0 and data low hold the 14-bit word.
- R4: Only a control write with bit 0 set can set the read strobe. Writing 0 to the bit never clears it, and the hardware clears it when the read finishes.
- R5: A control write with bit 1 set starts a write only if bit 2 is set in the same write and the previous two bus writes were 0x55 and then 0xAA to the unlock port. Otherwise the write strobe stays 0, no array write happens and the error bit reads 1. A control write with bit 3 clear, made while idle and not itself rejected, clears the error bit.
- R6: After an accepted write, exactly one array write pulse occurs, WRITE_CYCLES cycles after the accepting bus cycle. The write strobe reads 1 until the pulse. doneP is high for exactly the one following cycle, and from that cycle the write strobe reads 0.
- R7: A data-store write writes data low to address-low bits 5:0 and never raises coreStall.
- R8: While a read or write is in progress, bus writes to the control, address and data registers are ignored.
- R9: A program-store write holds coreStall high from the cycle after acceptance through the array write pulse. It writes {data high, data low} to the 11-bit address.
- R10: While coreStall is high irqOut stays low and any irqReq is held pending. A pending request appears on irqOut as a one-cycle pulse in the cycle after doneP.
- R11: The unlock port always reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe from the core |
| busAddr | input | 3 | Register offset |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data for busAddr |
| irqReq | input | 1 | Interrupt request from peripherals |
| irqOut | output | 1 | Interrupt request forwarded to the core |
| coreStall | output | 1 | Freezes the core during a program-store write |
| doneP | output | 1 | One-cycle write completion pulse |
| dmemAddr | output | 6 | Data-store address |
| dmemWdata | output | 8 | Data-store write data |
| dmemWe | output | 1 | Data-store write pulse |
| dmemRdata | input | 8 | Data-store read data |
| pmemAddr | output | 11 | Program-store address |
| pmemWdata | output | 14 | Program-store write data |
| pmemWe | output | 1 | Program-store write pulse |
| pmemRdata | input | 14 | Program-store read data |

## Verification
The bench reads addresses at and beyond each array's wrap point. A design that decodes too many address bits would return a neighbour's content. It checks that the read strobe is still set in the second cycle of a program read, which catches a design that treats both arrays with one latency. Rejected unlocks are exercised with the keys reversed, with a foreign write between them and with write enable missing; a lax guard would write the array. Bus writes made in the middle of a write must not change the stored value. An interrupt raised during a program write must not leak out during the stall, and must come out exactly once after doneP.

// File: rtl/nvmAccessPkg.sv
package nvmAccessPkg;
  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_UNLOCK = 3'd1;
  localparam logic [2:0] OFS_ADRL   = 3'd2;
  localparam logic [2:0] OFS_ADRH   = 3'd3;
  localparam logic [2:0] OFS_DATL   = 3'd4;
  localparam logic [2:0] OFS_DATH   = 3'd5;

  localparam int BIT_RD    = 0;
  localparam int BIT_WR    = 1;
  localparam int BIT_WREN  = 2;
  localparam int BIT_ERR   = 3;
  localparam int BIT_SPACE = 7;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef struct packed {
    logic loadRead;
    logic space;
    logic lockRegs;
  } nvmStrobes_t;

  typedef enum logic [1:0] {UL_IDLE, UL_FIRST, UL_ARMED} unlockState_t;
endpackage

// File: rtl/nvmDatapath.sv
module nvmDatapath
  import nvmAccessPkg::*;
#(
  parameter int DATA_AW = 6,
  parameter int PGM_AW  = 11,
  parameter int PGM_DW  = 14,
  parameter int FULL_AW = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic [2:0]          busAddr,
  input  logic [7:0]          busWdata,
  input  nvmStrobes_t         strb,
  input  logic [7:0]          ctrlReg,
  output logic [7:0]          busRdata,
  output logic [DATA_AW-1:0]  dmemAddr,
  output logic [7:0]          dmemWdata,
  input  logic [7:0]          dmemRdata,
  output logic [PGM_AW-1:0]   pmemAddr,
  output logic [PGM_DW-1:0]   pmemWdata,
  input  logic [PGM_DW-1:0]   pmemRdata
);
  localparam int HI_AW = FULL_AW - 8;
  localparam int HI_DW = PGM_DW - 8;

  logic [7:0]       addrLo;
  logic [HI_AW-1:0] addrHi;
  logic [7:0]       dataLo;
  logic [HI_DW-1:0] dataHi;
  logic [FULL_AW-1:0] fullAddr;

  assign fullAddr  = {addrHi, addrLo};
  assign pmemAddr  = fullAddr[PGM_AW-1:0];
  assign dmemAddr  = addrLo[DATA_AW-1:0];
  assign dmemWdata = dataLo;
  assign pmemWdata = {dataHi, dataLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLo <= '0;
      addrHi <= '0;
      dataLo <= '0;
      dataHi <= '0;
    end else if (strb.loadRead) begin
      if (strb.space) begin
        dataLo <= pmemRdata[7:0];
        dataHi <= pmemRdata[PGM_DW-1:8];
      end else begin
        dataLo <= dmemRdata;
      end
    end else if (busWe && !strb.lockRegs) begin
      case (busAddr)
        OFS_ADRL: addrLo <= busWdata;
        OFS_ADRH: addrHi <= busWdata[HI_AW-1:0];
        OFS_DATL: dataLo <= busWdata;
        OFS_DATH: dataHi <= busWdata[HI_DW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (busAddr)
      OFS_CTRL: busRdata = ctrlReg;
      OFS_ADRL: busRdata = addrLo;
      OFS_ADRH: busRdata = {{(8-HI_AW){1'b0}}, addrHi};
      OFS_DATL: busRdata = dataLo;
      OFS_DATH: busRdata = {{(8-HI_DW){1'b0}}, dataHi};
      default:  busRdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/nvmCtrlFsm.sv
module nvmCtrlFsm
  import nvmAccessPkg::*;
#(
  parameter int WRITE_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic [2:0]  busAddr,
  input  logic [7:0]  busWdata,
  input  logic        irqReq,
  output nvmStrobes_t strb,
  output logic [7:0]  ctrlReg,
  output logic        dmemWe,
  output logic        pmemWe,
  output logic        coreStall,
  output logic        doneP,
  output logic        irqOut
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic rdBit, rdCnt, wrBit, wren, err, space;
  logic irqPend, irqRel;
  logic [CW-1:0] cnt;
  unlockState_t ulState;

  logic busy, ctrlWr, wantWr, accept, reject, startRd, readDone, commit;

  assign busy     = rdBit | wrBit;
  assign ctrlWr   = busWe && (busAddr == OFS_CTRL) && !busy;
  assign wantWr   = ctrlWr && busWdata[BIT_WR];
  assign accept   = wantWr && busWdata[BIT_WREN] && (ulState == UL_ARMED);
  assign reject   = wantWr && !accept;
  assign startRd  = ctrlWr && busWdata[BIT_RD] && !busWdata[BIT_WR];
  assign readDone = rdBit && !rdCnt;
  assign commit   = wrBit && (cnt == '0);

  assign dmemWe    = commit && !space;
  assign pmemWe    = commit && space;
  assign coreStall = wrBit && space;
  assign irqOut    = (irqReq && !coreStall) || irqRel;

  assign strb.loadRead = readDone;
  assign strb.space    = space;
  assign strb.lockRegs = busy;

  assign ctrlReg = {space, 3'b000, err, wren, wrBit, rdBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdBit   <= 1'b0;
      rdCnt   <= 1'b0;
      wrBit   <= 1'b0;
      wren    <= 1'b0;
      err     <= 1'b0;
      space   <= 1'b0;
      cnt     <= '0;
      doneP   <= 1'b0;
      irqPend <= 1'b0;
      irqRel  <= 1'b0;
      ulState <= UL_IDLE;
    end else begin
      doneP  <= commit;
      irqRel <= irqPend && doneP;
      if (doneP) irqPend <= 1'b0;
      else if (irqReq && coreStall) irqPend <= 1'b1;

      if (busWe) begin
        if (busAddr == OFS_UNLOCK && busWdata == KEY_FIRST) ulState <= UL_FIRST;
        else if (busAddr == OFS_UNLOCK && busWdata == KEY_SECOND && ulState == UL_FIRST)
          ulState <= UL_ARMED;
        else ulState <= UL_IDLE;
      end

      if (ctrlWr) begin
        space <= busWdata[BIT_SPACE];
        wren  <= busWdata[BIT_WREN];
        err   <= reject || busWdata[BIT_ERR];
      end

      if (startRd) begin
        rdBit <= 1'b1;
        rdCnt <= busWdata[BIT_SPACE];
      end else if (rdBit) begin
        if (rdCnt) rdCnt <= 1'b0;
        else rdBit <= 1'b0;
      end

      if (accept) begin
        wrBit <= 1'b1;
        cnt   <= CW'(WRITE_CYCLES - 1);
      end else if (wrBit) begin
        if (cnt == '0) wrBit <= 1'b0;
        else cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/nvmAccessCtrl.sv
module nvmAccessCtrl
  import nvmAccessPkg::*;
#(
  parameter int DATA_AW      = 6,
  parameter int PGM_AW       = 11,
  parameter int PGM_DW       = 14,
  parameter int FULL_AW      = 13,
  parameter int WRITE_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic [2:0]         busAddr,
  input  logic [7:0]         busWdata,
  output logic [7:0]         busRdata,
  input  logic               irqReq,
  output logic               irqOut,
  output logic               coreStall,
  output logic               doneP,
  output logic [DATA_AW-1:0] dmemAddr,
  output logic [7:0]         dmemWdata,
  output logic               dmemWe,
  input  logic [7:0]         dmemRdata,
  output logic [PGM_AW-1:0]  pmemAddr,
  output logic [PGM_DW-1:0]  pmemWdata,
  output logic               pmemWe,
  input  logic [PGM_DW-1:0]  pmemRdata
);
  nvmStrobes_t strb;
  logic [7:0]  ctrlReg;

  nvmCtrlFsm #(.WRITE_CYCLES(WRITE_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .irqReq(irqReq), .strb(strb), .ctrlReg(ctrlReg), .dmemWe(dmemWe), .pmemWe(pmemWe),
    .coreStall(coreStall), .doneP(doneP), .irqOut(irqOut)
  );

  nvmDatapath #(.DATA_AW(DATA_AW), .PGM_AW(PGM_AW), .PGM_DW(PGM_DW), .FULL_AW(FULL_AW)) i_dp (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .strb(strb), .ctrlReg(ctrlReg), .busRdata(busRdata),
    .dmemAddr(dmemAddr), .dmemWdata(dmemWdata), .dmemRdata(dmemRdata),
    .pmemAddr(pmemAddr), .pmemWdata(pmemWdata), .pmemRdata(pmemRdata)
  );
endmodule

// File: rtl/nvmAccessChk.sv
module nvmAccessChk (
  input logic clk,
  input logic rstN,
  input logic dmemWe,
  input logic pmemWe,
  input logic coreStall,
  input logic doneP,
  input logic irqOut
);
  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dmemWe, pmemWe})); // R6
  AST_DONE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (dmemWe || pmemWe) |=> doneP); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP); // R6
  AST_DATA_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    dmemWe |-> !coreStall); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (coreStall && !pmemWe) |=> coreStall); // R9
  AST_STALL_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    pmemWe |=> !coreStall); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    coreStall |-> !irqOut); // R10
endmodule

bind nvmAccessCtrl nvmAccessChk i_chk (
  .clk(clk), .rstN(rstN), .dmemWe(dmemWe), .pmemWe(pmemWe),
  .coreStall(coreStall), .doneP(doneP), .irqOut(irqOut)
);

// File: tb/test_nvmAccessCtrl.sv
module test_nvmAccessCtrl;
  localparam int WC = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic irqReq = 1'b0;
  logic irqOut, coreStall, doneP, dmemWe, pmemWe;
  logic [5:0] dmemAddr;
  logic [7:0] dmemWdata, dmemRdata;
  logic [10:0] pmemAddr;
  logic [13:0] pmemWdata, pmemRdata;

  logic [7:0]  dmem [64];
  logic [13:0] pmem [2048];
  int dWeCnt = 0;
  int pWeCnt = 0;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  nvmAccessCtrl i_nvmAccessCtrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqReq(irqReq), .irqOut(irqOut), .coreStall(coreStall),
    .doneP(doneP), .dmemAddr(dmemAddr), .dmemWdata(dmemWdata), .dmemWe(dmemWe),
    .dmemRdata(dmemRdata), .pmemAddr(pmemAddr), .pmemWdata(pmemWdata), .pmemWe(pmemWe),
    .pmemRdata(pmemRdata)
  );

  assign dmemRdata = dmem[dmemAddr];
  assign pmemRdata = pmem[pmemAddr];

  always @(posedge clk) begin
    if (dmemWe) begin dmem[dmemAddr] <= dmemWdata; dWeCnt <= dWeCnt + 1; end
    if (pmemWe) begin pmem[pmemAddr] <= pmemWdata; pWeCnt <= pWeCnt + 1; end
  end

  function automatic logic [7:0] dpat(int i);
    return 8'(i * 7 + 3);
  endfunction
  function automatic logic [13:0] ppat(int i);
    return 14'(i * 37 + 5) ^ 14'h2A00;
  endfunction

  // {space, 2'b0, 13-bit address}
  localparam logic [15:0] VEC [8] = '{16'h0005, 16'h003F, 16'h0040, 16'h00C7,
                                      16'h8010, 16'h87FF, 16'h8800, 16'h9ABC};

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [2:0] a, logic [7:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readReg(logic [2:0] a, output logic [7:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic unlockKeys();
    busWrite(3'd1, 8'h55);
    busWrite(3'd1, 8'hAA);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, lo, hi;
    int n;
    for (int i = 0; i < 64; i++) dmem[i] = dpat(i);
    for (int i = 0; i < 2048; i++) pmem[i] = ppat(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      readReg(3'(a), v);
      chk("R1 reg", 16'(v), 16'h0);
    end
    chk("R1 stall/done/irq", {13'd0, coreStall, doneP, irqOut}, 16'h0);

    // R2 R3 table of reads
    for (int k = 0; k < 8; k++) begin
      logic sp;
      int wa;
      sp = VEC[k][15];
      busWrite(3'd2, VEC[k][7:0]);
      busWrite(3'd3, {3'b000, VEC[k][12:8]});
      busWrite(3'd0, {sp, 7'h01});
      readReg(3'd0, v);
      chk("R4 rd strobe set", 16'(v), 16'({sp, 7'h01}));
      @(negedge clk);
      if (sp) begin
        readReg(3'd0, v);
        chk("R3 rd held second cycle", 16'(v), 16'h81);
        @(negedge clk);
      end
      readReg(3'd0, v);
      chk("R4 rd self-cleared", 16'(v), 16'({sp, 7'h00}));
      readReg(3'd4, lo);
      readReg(3'd5, hi);
      if (sp) begin
        wa = int'(VEC[k][10:0]);
        chk("R3 program read", {2'b00, hi[5:0], lo}, {2'b00, ppat(wa)});
      end else begin
        wa = int'(VEC[k][5:0]);
        chk("R2 data read", 16'(lo), 16'(dpat(wa)));
      end
    end

    // R4 R8 write of 0 during a program read is ignored
    busWrite(3'd2, 8'h21);
    busWrite(3'd3, 8'h00);
    busWrite(3'd0, 8'h81);
    busWrite(3'd0, 8'h80);
    readReg(3'd0, v);
    chk("R4 zero write ignored", 16'(v), 16'h81);
    @(negedge clk);
    readReg(3'd4, lo);
    chk("R3 read after ignored write", 16'(lo), 16'(ppat(16'h21) & 14'hFF));

    // R7 R6 R8 data-store write
    busWrite(3'd2, 8'h4A);
    busWrite(3'd4, 8'h5C);
    unlockKeys();
    busWrite(3'd0, 8'h06);
    chk("R7 no stall", 16'(coreStall), 16'h0);
    readReg(3'd0, v);
    chk("R6 wr strobe set", 16'(v), 16'h06);
    busWrite(3'd0, 8'h01);
    readReg(3'd0, v);
    chk("R8 ctrl write ignored while busy", 16'(v), 16'h06);
    busWrite(3'd4, 8'h11);
    n = 3;
    while (!doneP && n < 40) begin
      if (coreStall) chk("R7 stall during data write", 16'(coreStall), 16'h0);
      @(negedge clk);
      n++;
    end
    chk("R6 done cycle", 16'(n), 16'(WC + 1));
    chk("R7 data stored", 16'(dmem[6'h0A]), 16'h5C);
    chk("R6 single data commit", 16'(dWeCnt), 16'h1);
    readReg(3'd0, v);
    chk("R6 wr strobe cleared", 16'(v), 16'h04);
    @(negedge clk);
    chk("R6 done one cycle", 16'(doneP), 16'h0);

    // R9 R10 program-store write with held interrupt
    busWrite(3'd2, 8'h23);
    busWrite(3'd3, 8'h0F);
    busWrite(3'd4, 8'hA5);
    busWrite(3'd5, 8'h3F);
    unlockKeys();
    busWrite(3'd0, 8'h86);
    chk("R9 stall raised", 16'(coreStall), 16'h1);
    irqReq = 1'b1;
    #1;
    chk("R10 irq masked", 16'(irqOut), 16'h0);
    @(negedge clk);
    irqReq = 1'b0;
    n = 2;
    while (!doneP && n < 40) begin
      if (!coreStall) chk("R9 stall held", 16'(coreStall), 16'h1);
      if (irqOut) chk("R10 irq during stall", 16'(irqOut), 16'h0);
      @(negedge clk);
      n++;
    end
    chk("R9 done cycle", 16'(n), 16'(WC + 1));
    chk("R9 stall released", 16'(coreStall), 16'h0);
    chk("R10 irq not yet", 16'(irqOut), 16'h0);
    @(negedge clk);
    chk("R10 irq released", 16'(irqOut), 16'h1);
    @(negedge clk);
    chk("R10 irq one pulse", 16'(irqOut), 16'h0);
    chk("R9 word stored", 16'(pmem[11'h723]), 16'h3FA5);
    chk("R9 single program commit", 16'(pWeCnt), 16'h1);
    busWrite(3'd0, 8'h81);
    repeat (2) @(negedge clk);
    readReg(3'd4, lo);
    readReg(3'd5, hi);
    chk("R9 readback", {hi, lo}, 16'h3FA5);

    // R5 rejected writes
    busWrite(3'd0, 8'h00);
    busWrite(3'd1, 8'hAA);
    busWrite(3'd1, 8'h55);
    busWrite(3'd0, 8'h06);
    readReg(3'd0, v);
    chk("R5 reversed keys", 16'(v), 16'h0C);
    busWrite(3'd0, 8'h00);
    readReg(3'd0, v);
    chk("R5 error cleared", 16'(v), 16'h00);
    busWrite(3'd1, 8'h55);
    busWrite(3'd2, 8'h0A);
    busWrite(3'd1, 8'hAA);
    busWrite(3'd0, 8'h06);
    readReg(3'd0, v);
    chk("R5 interrupted keys", 16'(v), 16'h0C);
    unlockKeys();
    busWrite(3'd0, 8'h02);
    readReg(3'd0, v);
    chk("R5 missing enable", 16'(v), 16'h08);
    repeat (WC + 4) @(negedge clk);
    chk("R5 no array write", 16'(dWeCnt + pWeCnt), 16'h2);

    // R11 unlock port reads zero
    busWrite(3'd1, 8'h55);
    readReg(3'd1, v);
    chk("R11 unlock reads zero", 16'(v), 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule